// File: doc/BRIEF.md
# Flash Command Interface Controller

This block decodes the byte-wide command traffic a host sends to an embedded flash macro. Host writes are framed by an active-low write strobe and host reads by an active-low output-enable strobe. Both strobes are sampled on the block clock and acted on at their edges. A single write selects the identifier readout, arms an operation, or returns the block to array reads. A second write confirms an erase, or carries the address and data of a program. A pair of `FFh` writes backs out of an armed or running operation.

While a program or erase runs, each read returns a status byte instead of array data. Bit 6 of that byte flips on every read. Bit 7 is the inverse of the bit 7 being programmed, and it is 0 during an erase. Bit 5 is set once the operation has failed. The array is modelled as a parameterised register file. The busy time of the engine is set by parameters. An erase first walks the array writing zero, waits, and then sets every byte to `FFh`.

The host side uses plain strobes, not a valid/ready stream. There is no back-pressure: the host learns that an operation has finished by polling status reads or by watching `op_busy`.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After a write of `90h`, a read at address 0 returns `C2h`, a read at address 1 returns `1Ah`, and a read at any other address returns `00h`.
- R2: A write of `30h` followed at once by a second write of `30h` erases the array, so that after completion every byte reads `FFh`.
- R3: After a write of `40h`, the next write is a program. Its address is taken when the write strobe falls and its data when the strobe rises, and that byte is stored at that address.
- R4: A write of `FFh` twice in a row after an erase or program set-up returns the block to array reads without altering any byte.
- R5: While an operation runs, bit 6 of successive reads alternates. Bit 7 reads as the inverse of programmed bit 7 during a program and as 0 during an erase.
- R6: Once a program finishes, two successive reads of its address agree in bit 6, and bits 7:6 equal the written data. The block is back in array-read mode.
- R7: A fault during an operation leaves the block reporting status with bit 5 set and bit 6 alternating. In this state every write other than the `FFh` pair is ignored. An `FFh` pair returns the block to array reads with the target byte unchanged.
- R8: Any write value other than `90h`, `30h` or `40h` in read or identifier mode, and any value other than `30h` or `FFh` after an erase set-up, returns the block to array reads.
- R9: While an operation runs, writes are ignored, except that two consecutive `FFh` writes abort it, leaving a program target unchanged.
- R10: After reset, the read data is `00h`, `op_busy` is low and reads return array contents (initially `FFh`).
- R11: `op_busy` rises right after the rising strobe edge of the confirming write. It stays low after a set-up write alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | AW (16) | Host byte address |
| bus_wdata | input | 8 | Host write data / command byte |
| bus_we_n | input | 1 | Active-low write strobe |
| bus_oe_n | input | 1 | Active-low read strobe |
| eng_fault | input | 1 | Program/erase failure report from the cell engine |
| bus_rdata | output | 8 | Read data: array, identifier or status byte |
| op_busy | output | 1 | High while an operation runs or a failure is pending |

## Verification
The assertions assume that the host never asserts both strobes at once. They also assume that each strobe stays low for at least one clock, so that both of its edges are seen, and that `bus_addr` is settled at the clock where the write strobe is first seen low. `eng_fault` is expected to be pulsed only while an operation is running. The bench drives every strobe from the falling clock edge and holds it low for two clocks. It changes address and data only mid-pulse, and only in the test that shows the two edges capture different fields. It raises the fault for one clock during a program.

// File: rtl/fci_pkg.sv
package fci_pkg;
  typedef enum logic [2:0] {
    M_READ, M_IDENT, M_ERA_ARM, M_PRG_ARM, M_ABORT1, M_BUSY, M_FAIL
  } mode_t;

  typedef enum logic [1:0] {E_IDLE, E_PROG, E_PRE, E_ERASE} eng_t;

  localparam logic [7:0] CMD_IDENT = 8'h90;
  localparam logic [7:0] CMD_ERASE = 8'h30;
  localparam logic [7:0] CMD_PROG  = 8'h40;
  localparam logic [7:0] CMD_RESET = 8'hFF;
  localparam logic [7:0] ID_MFR    = 8'hC2;
  localparam logic [7:0] ID_DEV    = 8'h1A;
endpackage

// File: rtl/fci_seq.sv
module fci_seq
  import fci_pkg::*;
#(
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_fall,
  input  logic          we_rise,
  input  logic [7:0]    wdata,
  input  logic [IW-1:0] addr,
  input  logic          eng_busy,
  input  logic          eng_done,
  input  logic          eng_fail,
  output mode_t         mode,
  output logic          op_erase,
  output logic          start_prog,
  output logic          start_erase,
  output logic          eng_abort,
  output logic [IW-1:0] prog_idx
);
  logic ff_pend;
  logic is_ff;

  assign is_ff       = (wdata == CMD_RESET);
  assign start_prog  = (mode == M_PRG_ARM) && we_rise && !is_ff;
  assign start_erase = (mode == M_ERA_ARM) && we_rise && (wdata == CMD_ERASE);
  assign eng_abort   = (mode == M_BUSY) && we_rise && is_ff && ff_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode     <= M_READ;
      ff_pend  <= 1'b0;
      op_erase <= 1'b0;
      prog_idx <= '0;
    end else begin
      if (we_fall) prog_idx <= addr;
      case (mode)
        M_READ, M_IDENT: begin
          if (we_rise) begin
            case (wdata)
              CMD_IDENT: mode <= M_IDENT;
              CMD_ERASE: mode <= M_ERA_ARM;
              CMD_PROG:  mode <= M_PRG_ARM;
              default:   mode <= M_READ;
            endcase
          end
        end
        M_ERA_ARM: begin
          if (we_rise) begin
            if (wdata == CMD_ERASE) begin
              mode     <= M_BUSY;
              op_erase <= 1'b1;
              ff_pend  <= 1'b0;
            end else if (is_ff) begin
              mode <= M_ABORT1;
            end else begin
              mode <= M_READ;
            end
          end
        end
        M_PRG_ARM: begin
          if (we_rise) begin
            if (is_ff) begin
              mode <= M_ABORT1;
            end else begin
              mode     <= M_BUSY;
              op_erase <= 1'b0;
              ff_pend  <= 1'b0;
            end
          end
        end
        M_ABORT1: if (we_rise) mode <= M_READ;
        M_BUSY, M_FAIL: begin
          if (mode == M_BUSY && eng_fail) begin
            mode    <= M_FAIL;
            ff_pend <= 1'b0;
          end else if (mode == M_BUSY && eng_done) begin
            mode <= M_READ;
          end else if (we_rise) begin
            if (is_ff && ff_pend) begin
              mode    <= M_READ;
              ff_pend <= 1'b0;
            end else begin
              ff_pend <= is_ff;
            end
          end
        end
        default: mode <= M_READ;
      endcase
    end
  end

  assert_start_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (start_prog || start_erase) |-> !eng_busy);
  assert_done_to_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_BUSY && eng_done && !eng_fail) |=> (mode == M_READ));
  assert_fail_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_FAIL && !we_rise) |=> (mode == M_FAIL));
endmodule

// File: rtl/fci_engine.sv
module fci_engine
  import fci_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int PROG_CYC  = 20,
  parameter int ERASE_CYC = 40,
  localparam int IW   = $clog2(DEPTH),
  localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC,
  localparam int CW   = $clog2(MAXC + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_prog,
  input  logic          start_erase,
  input  logic          abort,
  input  logic          fault,
  input  logic [IW-1:0] prog_idx,
  input  logic [7:0]    prog_data,
  input  logic [IW-1:0] rd_idx,
  output logic [7:0]    rd_data,
  output logic          pd7,
  output logic          busy,
  output logic          done,
  output logic          fail
);
  eng_t          state;
  logic [CW-1:0] cnt;
  logic [IW-1:0] walk;
  logic [IW-1:0] pa;
  logic [7:0]    pd;
  logic [7:0]    mem [DEPTH];

  assign busy    = (state != E_IDLE);
  assign fail    = busy && fault;
  assign done    = !fault && (cnt == '0) && (state == E_PROG || state == E_ERASE);
  assign rd_data = mem[rd_idx];
  assign pd7     = pd[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= E_IDLE;
      cnt   <= '0;
      walk  <= '0;
      pa    <= '0;
      pd    <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      case (state)
        E_IDLE: begin
          if (start_prog) begin
            pa    <= prog_idx;
            pd    <= prog_data;
            cnt   <= CW'(PROG_CYC - 1);
            state <= E_PROG;
          end else if (start_erase) begin
            walk  <= '0;
            state <= E_PRE;
          end
        end
        E_PROG: begin
          if (fault) state <= E_IDLE;
          else if (cnt == '0) begin
            mem[pa] <= pd;
            state   <= E_IDLE;
          end else if (abort) state <= E_IDLE;
          else cnt <= cnt - 1'b1;
        end
        E_PRE: begin
          if (fault || abort) state <= E_IDLE;
          else begin
            mem[walk] <= 8'h00;
            if (walk == IW'(DEPTH - 1)) begin
              cnt   <= CW'(ERASE_CYC - 1);
              state <= E_ERASE;
            end else begin
              walk <= walk + 1'b1;
            end
          end
        end
        E_ERASE: begin
          if (fault) state <= E_IDLE;
          else if (cnt == '0) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
            state <= E_IDLE;
          end else if (abort) state <= E_IDLE;
          else cnt <= cnt - 1'b1;
        end
        default: state <= E_IDLE;
      endcase
    end
  end

  assert_abort_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && busy && !done && !fault) |=> (state == E_IDLE));
  assert_erase_ff_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == E_ERASE && cnt == '0 && !fault) |=> (mem[0] == 8'hFF));
endmodule

// File: rtl/fci_status.sv
module fci_status
  import fci_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          oe_fall,
  input  mode_t         mode,
  input  logic          op_erase,
  input  logic          pd7,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    arr_data,
  output logic [7:0]    rdata
);
  logic tog;
  logic b7;

  assign b7 = op_erase ? 1'b0 : ~pd7;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata <= 8'h00;
      tog   <= 1'b0;
    end else if (oe_fall) begin
      case (mode)
        M_BUSY: begin
          rdata <= {b7, tog, 6'b0};
          tog   <= ~tog;
        end
        M_FAIL: begin
          rdata <= {b7, tog, 1'b1, 5'b0};
          tog   <= ~tog;
        end
        M_IDENT: begin
          if (addr == AW'(0))      rdata <= ID_MFR;
          else if (addr == AW'(1)) rdata <= ID_DEV;
          else                     rdata <= 8'h00;
        end
        default: rdata <= arr_data;
      endcase
    end
  end

  assert_ident_mfr_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_fall && mode == M_IDENT && addr == AW'(0)) |=> (rdata == ID_MFR));
  assert_fail_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_fall && mode == M_FAIL) |=> rdata[5]);
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fci_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DEPTH     = 16,
  parameter int PROG_CYC  = 20,
  parameter int ERASE_CYC = 40,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic [7:0]    bus_wdata,
  input  logic          bus_we_n,
  input  logic          bus_oe_n,
  input  logic          eng_fault,
  output logic [7:0]    bus_rdata,
  output logic          op_busy
);
  logic we_q, oe_q;
  logic we_fall, we_rise, oe_fall;
  mode_t mode;
  logic op_erase, start_prog, start_erase, eng_abort;
  logic [IW-1:0] prog_idx;
  logic eng_busy, eng_done, eng_fail, pd7;
  logic [7:0] arr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q <= 1'b1;
      oe_q <= 1'b1;
    end else begin
      we_q <= bus_we_n;
      oe_q <= bus_oe_n;
    end
  end

  assign we_fall = we_q && !bus_we_n;
  assign we_rise = !we_q && bus_we_n;
  assign oe_fall = oe_q && !bus_oe_n;
  assign op_busy = (mode == M_BUSY) || (mode == M_FAIL);

  fci_seq #(.IW(IW)) u_seq (
    .clk(clk), .rst_n(rst_n), .we_fall(we_fall), .we_rise(we_rise),
    .wdata(bus_wdata), .addr(bus_addr[IW-1:0]), .eng_busy(eng_busy),
    .eng_done(eng_done), .eng_fail(eng_fail), .mode(mode), .op_erase(op_erase),
    .start_prog(start_prog), .start_erase(start_erase), .eng_abort(eng_abort),
    .prog_idx(prog_idx)
  );

  fci_engine #(.DEPTH(DEPTH), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u_eng (
    .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
    .abort(eng_abort), .fault(eng_fault), .prog_idx(prog_idx), .prog_data(bus_wdata),
    .rd_idx(bus_addr[IW-1:0]), .rd_data(arr_data), .pd7(pd7), .busy(eng_busy),
    .done(eng_done), .fail(eng_fail)
  );

  fci_status #(.AW(AW)) u_stat (
    .clk(clk), .rst_n(rst_n), .oe_fall(oe_fall), .mode(mode), .op_erase(op_erase),
    .pd7(pd7), .addr(bus_addr), .arr_data(arr_data), .rdata(bus_rdata)
  );

  assert_busy_after_confirm_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_prog || start_erase) |=> op_busy);
endmodule

// File: tb/flash_cmd_ctrl_tb.sv
module flash_cmd_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_we_n = 1'b1;
  logic        bus_oe_n = 1'b1;
  logic        eng_fault = 1'b0;
  logic [7:0]  bus_rdata;
  logic        op_busy;
  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  flash_cmd_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we_n(bus_we_n), .bus_oe_n(bus_oe_n), .eng_fault(eng_fault),
    .bus_rdata(bus_rdata), .op_busy(op_busy)
  );

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_split(logic [15:0] a1, logic [7:0] d1, logic [15:0] a2, logic [7:0] d2);
    @(negedge clk); bus_addr = a1; bus_wdata = d1; bus_we_n = 1'b0;
    @(negedge clk); bus_addr = a2; bus_wdata = d2;
    @(negedge clk); bus_we_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wr(logic [15:0] a, logic [7:0] d);
    wr_split(a, d, a, d);
  endtask

  task automatic rd(logic [15:0] a, output logic [7:0] v);
    @(negedge clk); bus_addr = a; bus_oe_n = 1'b0;
    @(negedge clk);
    @(negedge clk); v = bus_rdata; bus_oe_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && op_busy; i++) @(negedge clk);
  endtask

  task automatic poll_prog(logic [15:0] a, logic [7:0] d, string req);
    logic [7:0] prev, cur;
    logic ok = 1'b0;
    rd(a, prev);
    for (int i = 0; i < 60 && !ok; i++) begin
      rd(a, cur);
      if (cur[6] == prev[6] && cur[7:6] == d[7:6]) ok = 1'b1;
      prev = cur;
    end
    chk(req, {7'b0, ok}, 8'h01);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R10 rdata after reset", bus_rdata, 8'h00);
    chk("R10 busy after reset", {7'b0, op_busy}, 8'h00);
    rd(16'h0007, v);
    chk("R10 array initial", v, 8'hFF);
  endtask

  task automatic t_ident();
    logic [7:0] v;
    wr(16'h0000, 8'h90);
    rd(16'h0000, v); chk("R1 manufacturer", v, 8'hC2);
    rd(16'h0001, v); chk("R1 device", v, 8'h1A);
    rd(16'h0005, v); chk("R1 other addr", v, 8'h00);
    wr(16'h0000, 8'hFF);
    rd(16'h0000, v); chk("R8 exit ident", v, 8'hFF);
  endtask

  task automatic t_unknown();
    logic [7:0] v;
    wr(16'h0000, 8'h90);
    wr(16'h0000, 8'h77);
    rd(16'h0001, v); chk("R8 unknown byte", v, 8'hFF);
  endtask

  task automatic t_prog_split();
    logic [7:0] a, b;
    wr(16'h0000, 8'h40);
    chk("R11 not busy after setup", {7'b0, op_busy}, 8'h00);
    wr_split(16'h0003, 8'h5A, 16'h0009, 8'h3C);
    chk("R11 busy after confirm", {7'b0, op_busy}, 8'h01);
    rd(16'h0003, a); rd(16'h0003, b);
    chk("R5 bit6 flips", {7'b0, a[6] ^ b[6]}, 8'h01);
    chk("R5 bit7 inverse", {7'b0, b[7]}, 8'h01);
    poll_prog(16'h0003, 8'h3C, "R6 poll completes");
    chk("R6 idle", {7'b0, op_busy}, 8'h00);
    rd(16'h0003, a); chk("R3 data at fall addr", a, 8'h3C);
    rd(16'h0009, a); chk("R3 other addr untouched", a, 8'hFF);
  endtask

  task automatic t_erase();
    logic [7:0] a, b;
    wr(16'h0000, 8'h30);
    chk("R11 not busy after erase setup", {7'b0, op_busy}, 8'h00);
    wr(16'h0000, 8'h30);
    rd(16'h0000, a); rd(16'h0000, b);
    chk("R5 erase bit6 flips", {7'b0, a[6] ^ b[6]}, 8'h01);
    chk("R5 erase bit7 zero", {7'b0, b[7]}, 8'h00);
    wait_idle();
    chk("R2 erase ended", {7'b0, op_busy}, 8'h00);
    for (int i = 0; i < 16; i++) begin
      rd(16'(i), a); chk("R2 erased byte", a, 8'hFF);
    end
  endtask

  task automatic t_setup_abort();
    logic [7:0] v;
    wr(16'h0000, 8'h40); wr(16'h0002, 8'h11);
    poll_prog(16'h0002, 8'h11, "R6 poll completes");
    wr(16'h0000, 8'h40); wr(16'h0002, 8'hFF); wr(16'h0002, 8'hFF);
    chk("R4 program abort idle", {7'b0, op_busy}, 8'h00);
    rd(16'h0002, v); chk("R4 program abort keeps", v, 8'h11);
    wr(16'h0000, 8'h30); wr(16'h0000, 8'hFF); wr(16'h0000, 8'hFF);
    chk("R4 erase abort idle", {7'b0, op_busy}, 8'h00);
    rd(16'h0002, v); chk("R4 erase abort keeps", v, 8'h11);
  endtask

  task automatic t_mismatch();
    logic [7:0] v;
    wr(16'h0000, 8'h30); wr(16'h0000, 8'h55); wr(16'h0000, 8'h30);
    chk("R8 mismatch no erase", {7'b0, op_busy}, 8'h00);
    wr(16'h0000, 8'h77);
    rd(16'h0002, v); chk("R8 mismatch array", v, 8'h11);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] v;
    wr(16'h0000, 8'h40); wr(16'h0004, 8'h22);
    wr(16'h0000, 8'h90);
    wait_idle();
    rd(16'h0004, v); chk("R9 program survives", v, 8'h22);
    rd(16'h0000, v); chk("R9 ident ignored", v, 8'hFF);
    wr(16'h0000, 8'h40); wr(16'h0005, 8'h33);
    wr(16'h0000, 8'hFF); wr(16'h0000, 8'hFF);
    chk("R9 busy abort idle", {7'b0, op_busy}, 8'h00);
    rd(16'h0005, v); chk("R9 aborted target", v, 8'hFF);
  endtask

  task automatic t_fail();
    logic [7:0] a, b;
    wr(16'h0000, 8'h40); wr(16'h0006, 8'h44);
    @(negedge clk); eng_fault = 1'b1;
    @(negedge clk); eng_fault = 1'b0;
    rd(16'h0006, a); rd(16'h0006, b);
    chk("R7 fail flag", {7'b0, a[5] & b[5]}, 8'h01);
    chk("R7 fail bit6 flips", {7'b0, a[6] ^ b[6]}, 8'h01);
    wr(16'h0000, 8'h90);
    rd(16'h0000, a); chk("R7 write ignored", {7'b0, a[5]}, 8'h01);
    chk("R7 still busy", {7'b0, op_busy}, 8'h01);
    wr(16'h0000, 8'hFF); wr(16'h0000, 8'hFF);
    chk("R7 cleared", {7'b0, op_busy}, 8'h00);
    rd(16'h0006, a); chk("R7 target unchanged", a, 8'hFF);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ident();
    t_unknown();
    t_prog_split();
    t_erase();
    t_setup_abort();
    t_mismatch();
    t_busy_ignore();
    t_fail();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule